// File: doc/BRIEF.md
# CPU Interrupt Pending Detector

This block keeps the two 8-bit fields a processor core consults when deciding whether to take a hardware interrupt. The first is the pending field of the cause register. The second is the interrupt mask field of the status register. From these two fields, a set of global gating bits and a mode select, it produces one registered interrupt request for the core. Vector generation is not part of this block.

The block has two modes. In line mode, pending bits 7:2 are sampled from six hardware interrupt lines on every clock edge. Pending bits 1:0 are software interrupts, and they change only when a software write occurs. A request is raised when at least one pending bit meets a set mask bit. In level mode, an external interrupt controller supplies an 8-bit level that loads the whole pending field. The mask field is then treated as a priority threshold, and a request is raised only when the pending level, read as an unsigned number, is strictly above that threshold.

The request is suppressed in any of these cases: the interrupt enable is low, the exception level is set, the error level is set, the running thread is exempt from interrupts, or the core is in debug mode.

Top module: `irq_pend_detect`

## Requirements
- R1: Synchronous active-high reset clears the pending field, the mask field and the request to zero.
- R2: In line mode (`ext_mode`=0), pending bits 7:2 take the value of `hw_lines[5:0]` at every clock edge, so hw_lines bit i appears at pending bit i+2.
- R3: In line mode, pending bits 1:0 load `sw_pend_wdata` on an edge where `sw_pend_we` is 1 and hold otherwise. In level mode a software pending write has no effect.
- R4: The mask field loads `mask_wdata` on an edge where `mask_we` is 1 and holds its value otherwise.
- R5: In line mode with the gates open, the request is 1 exactly when (pending AND mask) is nonzero, one edge after the fields hold those values.
- R6: In level mode (`ext_mode`=1), the whole pending field loads `ext_level` at every clock edge.
- R7: In level mode with the gates open, the request is 1 exactly when pending > mask as unsigned 8-bit values. Equal values give no request.
- R8: When `int_en` is 0, the request is 0 one edge later.
- R9: When `exc_lvl` is 1, the request is 0 one edge later.
- R10: When `err_lvl` is 1, the request is 0 one edge later.
- R11: When `thr_exempt` is 1, the request is 0 one edge later.
- R12: When `dbg_mode` is 1, the request is 0 one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 0 = line mode, 1 = external controller level mode |
| hw_lines | input | 6 | Hardware interrupt lines for pending bits 7:2 |
| ext_level | input | 8 | Level vector from the external controller |
| sw_pend_we | input | 1 | Write strobe for software pending bits 1:0 |
| sw_pend_wdata | input | 2 | Data for software pending bits 1:0 |
| mask_we | input | 1 | Write strobe for the mask field |
| mask_wdata | input | 8 | Data for the mask field |
| int_en | input | 1 | Global interrupt enable |
| exc_lvl | input | 1 | Exception level active |
| err_lvl | input | 1 | Error level active |
| thr_exempt | input | 1 | Current thread is exempt from interrupts |
| dbg_mode | input | 1 | Debug mode active |
| pend_o | output | 8 | Current pending field |
| mask_o | output | 8 | Current mask field |
| irq_req | output | 1 | Registered interrupt request |

## Verification
After a stimulus on the lines, the level vector or a write port, the pending and mask fields change on the next edge. The request follows one edge after that. A gating input acts on the request one edge after it changes.

Each directed task applies its inputs just after a rising edge. It then waits one edge before checking the fields and two edges before checking the request, or one edge before checking the request after a gating change. All sampling happens 1 ns after the edge.

The tasks cover the following cases:
- the behaviour at reset,
- each gate on its own,
- a sweep of every pending bit against every mask bit in line mode,
- the level compare in level mode, including the equal-level and top-bit cases.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned FIELD_W_DEF = 8;
    localparam int unsigned SW_BITS_DEF = 2;

    typedef enum logic {
        MODE_LINE  = 1'b0,
        MODE_LEVEL = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic int_en;
        logic exc_lvl;
        logic err_lvl;
        logic thr_exempt;
        logic dbg_mode;
    } irq_gate_t;

    function automatic logic gate_open(input irq_gate_t g);
        return g.int_en & ~g.exc_lvl & ~g.err_lvl & ~g.thr_exempt & ~g.dbg_mode;
    endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
    import irq_pkg::*;
#(
    parameter int unsigned W   = FIELD_W_DEF,
    parameter int unsigned SWB = SW_BITS_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  irq_mode_e            mode,
    input  logic [W-SWB-1:0]     hw,
    input  logic [W-1:0]         lvl,
    input  logic                 sw_we,
    input  logic [SWB-1:0]       sw_data,
    output logic [W-1:0]         pend_q
);

    logic [W-1:0] pend_nxt;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (b < SWB) begin : g_soft
            assign pend_nxt[b] = (mode == MODE_LEVEL) ? lvl[b]
                               : (sw_we ? sw_data[b] : pend_q[b]);
        end else begin : g_hard
            assign pend_nxt[b] = (mode == MODE_LEVEL) ? lvl[b] : hw[b-SWB];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_nxt;
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_pkg::*;
#(
    parameter int unsigned W = FIELD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst)     mask_q <= '0;
        else if (we) mask_q <= wdata;
    end

endmodule

// File: rtl/irq_eval.sv
module irq_eval
    import irq_pkg::*;
#(
    parameter int unsigned W = FIELD_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  irq_mode_e    mode,
    input  irq_gate_t    gate,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] mask,
    output logic         req_q
);

    logic hit_line;
    logic hit_level;
    logic hit;

    assign hit_line  = |(pend & mask);
    assign hit_level = pend > mask;
    assign hit       = (mode == MODE_LEVEL) ? hit_level : hit_line;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= gate_open(gate) & hit;
    end

endmodule

// File: rtl/irq_pend_detect.sv
module irq_pend_detect
    import irq_pkg::*;
#(
    parameter int unsigned FIELD_W = FIELD_W_DEF,
    parameter int unsigned SW_BITS = SW_BITS_DEF,
    localparam int unsigned HW_W   = FIELD_W - SW_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_mode,
    input  logic [HW_W-1:0]    hw_lines,
    input  logic [FIELD_W-1:0] ext_level,
    input  logic               sw_pend_we,
    input  logic [SW_BITS-1:0] sw_pend_wdata,
    input  logic               mask_we,
    input  logic [FIELD_W-1:0] mask_wdata,
    input  logic               int_en,
    input  logic               exc_lvl,
    input  logic               err_lvl,
    input  logic               thr_exempt,
    input  logic               dbg_mode,
    output logic [FIELD_W-1:0] pend_o,
    output logic [FIELD_W-1:0] mask_o,
    output logic               irq_req
);

    irq_mode_e mode;
    irq_gate_t gate;

    assign mode = irq_mode_e'(ext_mode);
    assign gate = '{int_en: int_en, exc_lvl: exc_lvl, err_lvl: err_lvl,
                    thr_exempt: thr_exempt, dbg_mode: dbg_mode};

    irq_pend_reg #(.W(FIELD_W), .SWB(SW_BITS)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .hw      (hw_lines),
        .lvl     (ext_level),
        .sw_we   (sw_pend_we),
        .sw_data (sw_pend_wdata),
        .pend_q  (pend_o)
    );

    irq_mask_reg #(.W(FIELD_W)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .we     (mask_we),
        .wdata  (mask_wdata),
        .mask_q (mask_o)
    );

    irq_eval #(.W(FIELD_W)) u_eval (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .gate  (gate),
        .pend  (pend_o),
        .mask  (mask_o),
        .req_q (irq_req)
    );

endmodule

// File: rtl/irq_pend_detect_chk.sv
module irq_pend_detect_chk #(
    parameter int unsigned FIELD_W = 8,
    parameter int unsigned SW_BITS = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       ext_mode,
    input logic [FIELD_W-SW_BITS-1:0] hw_lines,
    input logic [FIELD_W-1:0]         ext_level,
    input logic                       mask_we,
    input logic                       int_en,
    input logic                       exc_lvl,
    input logic                       err_lvl,
    input logic                       thr_exempt,
    input logic                       dbg_mode,
    input logic [FIELD_W-1:0]         pend_o,
    input logic [FIELD_W-1:0]         mask_o,
    input logic                       irq_req
);

    logic open_g;
    assign open_g = int_en && !exc_lvl && !err_lvl && !thr_exempt && !dbg_mode;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!irq_req && pend_o == '0 && mask_o == '0)); // R1
    AST_LINES_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        !ext_mode |=> pend_o[FIELD_W-1:SW_BITS] == $past(hw_lines)); // R2
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_o)); // R4
    AST_LINE_REQ: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && open_g && (pend_o & mask_o) != '0) |=> irq_req); // R5
    AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        ext_mode |=> pend_o == $past(ext_level)); // R6
    AST_LEVEL_NOREQ: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && pend_o <= mask_o) |=> !irq_req); // R7
    AST_IE_BLOCK: assert property (@(posedge clk) disable iff (rst)
        !int_en |=> !irq_req); // R8
    AST_EXL_BLOCK: assert property (@(posedge clk) disable iff (rst)
        exc_lvl |=> !irq_req); // R9
    AST_ERL_BLOCK: assert property (@(posedge clk) disable iff (rst)
        err_lvl |=> !irq_req); // R10
    AST_EXEMPT_BLOCK: assert property (@(posedge clk) disable iff (rst)
        thr_exempt |=> !irq_req); // R11
    AST_DEBUG_BLOCK: assert property (@(posedge clk) disable iff (rst)
        dbg_mode |=> !irq_req); // R12

endmodule

bind irq_pend_detect irq_pend_detect_chk #(.FIELD_W(FIELD_W), .SW_BITS(SW_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_mode   (ext_mode),
    .hw_lines   (hw_lines),
    .ext_level  (ext_level),
    .mask_we    (mask_we),
    .int_en     (int_en),
    .exc_lvl    (exc_lvl),
    .err_lvl    (err_lvl),
    .thr_exempt (thr_exempt),
    .dbg_mode   (dbg_mode),
    .pend_o     (pend_o),
    .mask_o     (mask_o),
    .irq_req    (irq_req)
);

// File: tb/irq_pend_detect_tb_top.sv
`timescale 1ns/1ps
module irq_pend_detect_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       ext_mode;
    logic [5:0] hw_lines;
    logic [7:0] ext_level;
    logic       sw_pend_we;
    logic [1:0] sw_pend_wdata;
    logic       mask_we;
    logic [7:0] mask_wdata;
    logic       int_en, exc_lvl, err_lvl, thr_exempt, dbg_mode;
    logic [7:0] pend_o, mask_o;
    logic       irq_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_pend_detect dut_i (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .hw_lines(hw_lines),
        .ext_level(ext_level), .sw_pend_we(sw_pend_we), .sw_pend_wdata(sw_pend_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .int_en(int_en),
        .exc_lvl(exc_lvl), .err_lvl(err_lvl), .thr_exempt(thr_exempt),
        .dbg_mode(dbg_mode), .pend_o(pend_o), .mask_o(mask_o), .irq_req(irq_req)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_mask(input logic [7:0] m);
        mask_we = 1'b1; mask_wdata = m;
        tick(1);
        mask_we = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; ext_mode = 1'b0; hw_lines = '0; ext_level = '0;
        sw_pend_we = 1'b0; sw_pend_wdata = '0; mask_we = 1'b0; mask_wdata = '0;
        int_en = 1'b1; exc_lvl = 1'b0; err_lvl = 1'b0; thr_exempt = 1'b0; dbg_mode = 1'b0;
        tick(3);
        check("R1 req", {7'd0, irq_req}, 8'h00);
        check("R1 pend", pend_o, 8'h00);
        check("R1 mask", mask_o, 8'h00);
        rst = 1'b0;
        tick(1);
    endtask

    task automatic t_lines;
        hw_lines = 6'b101101;
        tick(1);
        check("R2 lines", {2'b00, pend_o[7:2]}, 8'h2D);
        hw_lines = 6'b010010;
        tick(1);
        check("R2 lines change", {2'b00, pend_o[7:2]}, 8'h12);
        hw_lines = '0;
        tick(1);
    endtask

    task automatic t_soft;
        sw_pend_we = 1'b1; sw_pend_wdata = 2'b10;
        tick(1);
        sw_pend_we = 1'b0; sw_pend_wdata = 2'b01;
        check("R3 soft write", {6'd0, pend_o[1:0]}, 8'h02);
        tick(2);
        check("R3 soft hold", {6'd0, pend_o[1:0]}, 8'h02);
        sw_pend_we = 1'b1; sw_pend_wdata = 2'b00;
        tick(1);
        sw_pend_we = 1'b0;
    endtask

    task automatic t_mask;
        set_mask(8'hA5);
        mask_wdata = 8'h3C;
        check("R4 mask write", mask_o, 8'hA5);
        tick(2);
        check("R4 mask hold", mask_o, 8'hA5);
    endtask

    task automatic t_sweep;
        for (int p = 0; p < 8; p++) begin
            for (int m = 0; m < 8; m++) begin
                hw_lines      = (p >= 2) ? 6'(1 << (p - 2)) : 6'd0;
                sw_pend_we    = 1'b1;
                sw_pend_wdata = (p < 2) ? 2'(1 << p) : 2'd0;
                mask_we       = 1'b1;
                mask_wdata    = 8'(1 << m);
                tick(1);
                sw_pend_we = 1'b0; mask_we = 1'b0;
                tick(1);
                check($sformatf("R5 sweep p%0d m%0d", p, m), {7'd0, irq_req},
                      (p == m) ? 8'h01 : 8'h00);
            end
        end
        hw_lines = '0;
        sw_pend_we = 1'b1; sw_pend_wdata = '0;
        tick(1);
        sw_pend_we = 1'b0;
    endtask

    task automatic t_level;
        ext_mode = 1'b1;
        set_mask(8'h40);
        ext_level = 8'h41;
        tick(1);
        check("R6 level load", pend_o, 8'h41);
        tick(1);
        check("R7 above", {7'd0, irq_req}, 8'h01);
        ext_level = 8'h40;
        tick(2);
        check("R7 equal", {7'd0, irq_req}, 8'h00);
        ext_level = 8'h3F;
        tick(2);
        check("R7 below", {7'd0, irq_req}, 8'h00);
        set_mask(8'h7F);
        ext_level = 8'h80;
        tick(2);
        check("R7 unsigned top bit", {7'd0, irq_req}, 8'h01);
        sw_pend_we = 1'b1; sw_pend_wdata = 2'b11; ext_level = 8'h40;
        tick(1);
        sw_pend_we = 1'b0;
        check("R3 soft ignored in level", pend_o, 8'h40);
        ext_mode = 1'b0; ext_level = '0;
        tick(1);
    endtask

    task automatic arm;
        hw_lines = 6'b000001;
        set_mask(8'h04);
        tick(1);
        check("R5 armed", {7'd0, irq_req}, 8'h01);
    endtask

    task automatic t_gates;
        arm();
        int_en = 1'b0; tick(1);
        check("R8 ie low", {7'd0, irq_req}, 8'h00);
        int_en = 1'b1; tick(1);
        check("R8 ie restored", {7'd0, irq_req}, 8'h01);
        exc_lvl = 1'b1; tick(1);
        check("R9 exl", {7'd0, irq_req}, 8'h00);
        exc_lvl = 1'b0; tick(1);
        check("R9 exl restored", {7'd0, irq_req}, 8'h01);
        err_lvl = 1'b1; tick(1);
        check("R10 erl", {7'd0, irq_req}, 8'h00);
        err_lvl = 1'b0; tick(1);
        check("R10 erl restored", {7'd0, irq_req}, 8'h01);
        thr_exempt = 1'b1; tick(1);
        check("R11 exempt", {7'd0, irq_req}, 8'h00);
        thr_exempt = 1'b0; tick(1);
        check("R11 exempt restored", {7'd0, irq_req}, 8'h01);
        dbg_mode = 1'b1; tick(1);
        check("R12 debug", {7'd0, irq_req}, 8'h00);
        dbg_mode = 1'b0; tick(1);
        check("R12 debug restored", {7'd0, irq_req}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_lines();
        t_soft();
        t_mask();
        t_sweep();
        t_level();
        t_gates();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule